// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the feedback divider of a frequency synthesizer loop. It divides its input clock by N = B·P + A. A dual-modulus prescaler divides the input clock by P or by P+1. A swallow counter and a main counter both step on the prescaler's output. While the swallow count is non-zero, the prescaler runs at P+1. Once the swallow count reaches zero, it runs at P for the rest of the main count. When the main counter reaches its terminal count, both counters reload and the block emits a single-cycle pulse. That pulse goes to the phase detector of the loop.

The modulus base P is chosen with a two-bit select from 8, 16, 32 and 64. Programmed values are captured only at a terminal count, or while reset is held, so a divide period is never cut short. A plain error output flags settings the counters cannot divide correctly. For simulation, the prescaler is a programmable counter in the same clock domain as the rest of the block.

Top module: `swallow_divider`

## Requirements
- R1: While `rst` is high on a rising edge, the block loads the current `mod_sel`, `swallow_val` and `main_val` and holds `div_pulse` low on the following cycle.
- R2: With a legal setting, consecutive rising edges of `div_pulse` are exactly `main_val`·P + `swallow_val` input cycles apart. P is 8, 16, 32 or 64 for `mod_sel` = 0, 1, 2 or 3 respectively.
- R3: With `swallow_val` = 0, every prescaler period uses P and the spacing is `main_val`·P.
- R4: With `swallow_val` equal to `main_val`, every prescaler period uses P+1 and the spacing is `main_val`·(P+1).
- R5: `div_pulse` is high for exactly one input cycle per divide period.
- R6: Values changed during a divide period do not affect that period. The period that starts at the next terminal count uses the new values.
- R7: `cfg_err` is high, combinationally, when `swallow_val` is greater than `main_val` or when `main_val` is below 3, and is low otherwise.
- R8: The boundary settings `main_val` = 3 and `swallow_val` = 63 divide per R2.
- R9: The main count steps down by one on each prescaler output tick that is not terminal, and the counters hold between ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high; also loads the settings |
| mod_sel | input | 2 | Prescaler base select: 0→8, 1→16, 2→32, 3→64 |
| swallow_val | input | 6 | Swallow count A (0 to 63) |
| main_val | input | 13 | Main count B (3 to 8191) |
| div_pulse | output | 1 | One-cycle pulse once per N input cycles |
| cfg_err | output | 1 | Setting flagged illegal (A > B or B < 3) |

## Verification
The hardest case to reach from the ports is a change of settings arriving in the middle of a divide period. The divider must finish that period with the old ratio and switch only at the terminal count. The bench waits for a pulse, changes all three settings on the next falling edge, and measures two intervals. The first must match the old ratio and the second the new one. Separate scenarios drive the swallow count to zero and to its full value, so the prescaler stays at one modulus for a whole period.

// File: rtl/swd_pkg.sv
package swd_pkg;
  // Prescaler counter width: must hold the largest modulus (64 + 1).
  localparam int MOD_W   = 7;
  // Base modulus is 2**(BASE_LOG + select).
  localparam int BASE_LOG = 3;
  localparam int SEL_W   = 2;

  typedef enum logic [SEL_W-1:0] {
    MODSEL_8  = 2'd0,
    MODSEL_16 = 2'd1,
    MODSEL_32 = 2'd2,
    MODSEL_64 = 2'd3
  } mod_sel_e;

  function automatic logic [MOD_W-1:0] base_modulus(input logic [SEL_W-1:0] sel);
    logic [MOD_W-1:0] one;
    one = {{(MOD_W-1){1'b0}}, 1'b1};
    return one << (BASE_LOG + int'(sel));
  endfunction
endpackage

// File: rtl/swd_prescaler.sv
// Dual-modulus prescaler: counts P or P+1 input cycles per output tick.
module swd_prescaler
  import swd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             mod_hi,
  output logic             tick
);
  logic [SEL_W-1:0] sel_q;
  logic [MOD_W-1:0] phase_q;
  logic [MOD_W-1:0] period_len;

  always_comb begin
    period_len = base_modulus(sel_q) + {{(MOD_W-1){1'b0}}, mod_hi};
    tick       = (phase_q == period_len - {{(MOD_W-1){1'b0}}, 1'b1});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      sel_q   <= sel_in;
    end else if (tick) begin
      phase_q <= '0;
      if (load) sel_q <= sel_in;
    end else begin
      phase_q <= phase_q + {{(MOD_W-1){1'b0}}, 1'b1};
    end
  end
endmodule

// File: rtl/swd_counters.sv
// Swallow (A) and main (B) counters stepped by the prescaler tick.
module swd_counters #(
  parameter int A_W = 6,
  parameter int B_W = 13
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  output logic           mod_hi,
  output logic           term,
  output logic           pulse,
  output logic [A_W-1:0] a_cnt,
  output logic [B_W-1:0] b_cnt
);
  localparam logic [B_W-1:0] B_ONE = {{(B_W-1){1'b0}}, 1'b1};
  localparam logic [A_W-1:0] A_ONE = {{(A_W-1){1'b0}}, 1'b1};

  logic b_last;

  always_comb begin
    mod_hi = (a_cnt != '0);
    // A main value of 0 behaves as 1 (flagged as illegal elsewhere).
    b_last = (b_cnt <= B_ONE);
    term   = tick && b_last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_cnt <= a_in;
      b_cnt <= b_in;
      pulse <= 1'b0;
    end else begin
      pulse <= term;
      if (term) begin
        a_cnt <= a_in;
        b_cnt <= b_in;
      end else if (tick) begin
        b_cnt <= b_cnt - B_ONE;
        if (mod_hi) a_cnt <= a_cnt - A_ONE;
      end
    end
  end
endmodule

// File: rtl/swd_cfg_check.sv
// Flags settings the swallow scheme cannot divide correctly.
module swd_cfg_check #(
  parameter int A_W   = 6,
  parameter int B_W   = 13,
  parameter int MIN_B = 3
) (
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  output logic           err
);
  localparam logic [B_W-1:0] B_FLOOR = B_W'(MIN_B);
  logic [B_W-1:0] a_wide;

  always_comb begin
    a_wide = {{(B_W-A_W){1'b0}}, a_in};
    err    = (a_wide > b_in) || (b_in < B_FLOOR);
  end
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swd_pkg::*;
#(
  parameter int A_W   = 6,
  parameter int B_W   = 13,
  parameter int MIN_B = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] mod_sel,
  input  logic [A_W-1:0]   swallow_val,
  input  logic [B_W-1:0]   main_val,
  output logic             div_pulse,
  output logic             cfg_err
);
  logic           pre_tick;
  logic           mod_hi;
  logic           term;
  logic [A_W-1:0] a_cnt;
  logic [B_W-1:0] b_cnt;

  swd_prescaler u_pre (
    .clk    (clk),
    .rst    (rst),
    .load   (term),
    .sel_in (mod_sel),
    .mod_hi (mod_hi),
    .tick   (pre_tick)
  );

  swd_counters #(.A_W(A_W), .B_W(B_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .tick   (pre_tick),
    .a_in   (swallow_val),
    .b_in   (main_val),
    .mod_hi (mod_hi),
    .term   (term),
    .pulse  (div_pulse),
    .a_cnt  (a_cnt),
    .b_cnt  (b_cnt)
  );

  swd_cfg_check #(.A_W(A_W), .B_W(B_W), .MIN_B(MIN_B)) u_chkcfg (
    .a_in (swallow_val),
    .b_in (main_val),
    .err  (cfg_err)
  );
endmodule

// File: rtl/swd_chk.sv
module swd_chk #(
  parameter int A_W = 6,
  parameter int B_W = 13
) (
  input logic           clk,
  input logic           rst,
  input logic           div_pulse,
  input logic           pre_tick,
  input logic [A_W-1:0] swallow_val,
  input logic [B_W-1:0] main_val,
  input logic [A_W-1:0] a_cnt,
  input logic [B_W-1:0] b_cnt
);
  localparam logic [B_W-1:0] B_ONE = {{(B_W-1){1'b0}}, 1'b1};
  logic [15:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst || div_pulse) gap_q <= '0;
    else if (gap_q != 16'hFFFF) gap_q <= gap_q + 16'd1;
  end

  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);

  // R6
  reload_val_chk: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> (b_cnt == $past(main_val)) && (a_cnt == $past(swallow_val)));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pre_tick |=> $stable(a_cnt) && $stable(b_cnt));

  // R9
  count_down_chk: assert property (@(posedge clk) disable iff (rst)
    (pre_tick && (b_cnt > B_ONE)) |=> (b_cnt == $past(b_cnt) - B_ONE));

  // R2
  always_ff @(posedge clk) begin
    if (!rst && div_pulse) begin
      min_gap_chk: assert (gap_q >= 16'd7);
    end
  end
endmodule

bind swallow_divider swd_chk #(.A_W(A_W), .B_W(B_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .div_pulse   (div_pulse),
  .pre_tick    (pre_tick),
  .swallow_val (swallow_val),
  .main_val    (main_val),
  .a_cnt       (a_cnt),
  .b_cnt       (b_cnt)
);

// File: tb/swallow_divider_tb.sv
module swallow_divider_tb;
  localparam int CLK_PERIOD = 10;
  localparam int GAP_LIMIT  = 70000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mod_sel = 2'd0;
  logic [5:0]  swallow_val = 6'd0;
  logic [12:0] main_val = 13'd3;
  logic        div_pulse;
  logic        cfg_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swallow_divider u_dut (
    .clk         (clk),
    .rst         (rst),
    .mod_sel     (mod_sel),
    .swallow_val (swallow_val),
    .main_val    (main_val),
    .div_pulse   (div_pulse),
    .cfg_err     (cfg_err)
  );

  function automatic int ratio(int sel, int a, int b);
    return b * (8 << sel) + a;
  endfunction

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts falling edges until div_pulse is seen high.
  task automatic wait_pulse(output int cycles);
    cycles = 0;
    do begin
      @(negedge clk);
      cycles++;
    end while (!div_pulse && cycles < GAP_LIMIT);
  endtask

  task automatic apply_reset(int sel, int a, int b);
    @(negedge clk);
    rst = 1'b1;
    mod_sel = 2'(sel); swallow_val = 6'(a); main_val = 13'(b);
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset;
    apply_reset(0, 1, 4);
    rst = 1'b1;
    @(negedge clk);
    check("R1 pulse low in reset", int'(div_pulse), 0);
    rst = 1'b0;
  endtask

  // Measures two consecutive periods after the first pulse.
  task automatic t_ratio(string req, int sel, int a, int b);
    int c;
    apply_reset(sel, a, b);
    wait_pulse(c);
    @(negedge clk);
    check({req, " pulse one cycle"}, int'(div_pulse), 0);
    wait_pulse(c);
    check({req, " period"}, c + 1, ratio(sel, a, b));
    wait_pulse(c);
    check({req, " repeat period"}, c, ratio(sel, a, b));
  endtask

  task automatic t_change;
    int c;
    apply_reset(0, 2, 5);
    wait_pulse(c);
    mod_sel = 2'd1; swallow_val = 6'd4; main_val = 13'd7;
    wait_pulse(c);
    check("R6 old ratio kept", c, ratio(0, 2, 5));
    wait_pulse(c);
    check("R6 new ratio used", c, ratio(1, 4, 7));
  endtask

  task automatic t_err;
    @(negedge clk);
    swallow_val = 6'd10; main_val = 13'd5; #1;
    check("R7 A>B flagged", int'(cfg_err), 1);
    swallow_val = 6'd5; main_val = 13'd5; #1;
    check("R7 A=B legal", int'(cfg_err), 0);
    swallow_val = 6'd0; main_val = 13'd2; #1;
    check("R7 B<3 flagged", int'(cfg_err), 1);
    main_val = 13'd3; #1;
    check("R7 B=3 legal", int'(cfg_err), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ratio("R2 sel0", 0, 3, 10);
    t_ratio("R2 sel1", 1, 5, 9);
    t_ratio("R2 sel2", 2, 7, 12);
    t_ratio("R2 sel3", 3, 2, 4);
    t_ratio("R3 A=0", 1, 0, 6);
    t_ratio("R4 A=B", 2, 9, 9);
    t_ratio("R8 B=3", 0, 1, 3);
    t_ratio("R8 A=63", 3, 63, 63);
    t_change();
    t_err();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule